// File: doc/BRIEF.md
# Three-Wire Handshake Byte Mover

This block carries bytes in both directions between a host and a peripheral controller, one byte at a time. It does not use a shift clock. Each byte is paced by three active-low handshake lines. The host drives a busy line, which marks a transfer in progress, and an acknowledge line. The block drives a request line back to the host. A direction input from the host selects the flow. When it is high, bytes from the host's shift register are collected into an outbound packet buffer. When it is low, bytes of a queued response are presented one by one for the shift register to load.

A byte moves whenever the sampled pair of busy and acknowledge differs from the pair seen one cycle earlier while busy is low. When the host is idle, toggling acknowledge acts as a sync handshake, and the request line copies acknowledge. When busy is released, a packet-received strobe reports how many outbound bytes arrived. Every byte step, sync toggle, end of transfer and response load starts a delay timer, and the timer then emits a one-cycle shift-register interrupt. A newer start replaces a pending one.

Top module: `hs_byte_xfer`

## Requirements
- R1: While and right after reset, `req_n_o` is 1, and `sr_irq_o`, `pkt_valid_o` and `sr_load_o` are 0.
- R2: While `busy_n_i` is 0, a change of `busy_n_i` or `ack_n_i` from the value sampled at the previous clock edge moves exactly one byte. With no such change, nothing moves.
- R3: With `shift_out_i` = 1, each byte step writes `sr_data_i` into the outbound buffer at the next index, starting at 0. `pkt_rdata_o` returns the entry addressed by `pkt_raddr_i` one cycle after the address is presented.
- R4: Outbound bytes beyond `OUT_DEPTH` are dropped. The count stops at `OUT_DEPTH`, and the bytes already stored are unchanged.
- R5: When `busy_n_i` goes from 0 to 1 and at least one outbound byte was collected, `pkt_valid_o` is 1 for one cycle, one cycle after the sampling edge, with `pkt_len_o` equal to the count. The count then returns to 0. With no bytes collected, no strobe appears.
- R6: With `shift_out_i` = 0, each byte step pulses `sr_load_o` for one cycle and places the next response byte on `sr_data_o`, one cycle after the sampling edge. Steps made when no response byte is left are ignored.
- R7: When the last response byte is loaded, `req_n_o` goes to 1 in the same cycle as that load.
- R8: If `busy_n_i` is 1 at the current edge and was 1 at the previous edge, and `ack_n_i` changed, `req_n_o` takes the new value of `ack_n_i`.
- R9: If `busy_n_i` is 1, no sync toggle occurs, and response bytes remain unsent, `req_n_o` is driven to 0.
- R10: A byte step, a sync toggle, a busy release or a response load makes `sr_irq_o` pulse high for one cycle exactly `IRQ_DELAY` clock edges after the edge that sampled the event.
- R11: A new interrupt event while one is pending restarts the delay, so only one pulse results, timed from the latest event.
- R12: `rsp_commit_i` sets the response length to `rsp_len_i` (capped at `IN_DEPTH`) and restarts the response from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_n_i | input | 1 | Host transfer-in-progress line, active low |
| ack_n_i | input | 1 | Host acknowledge line, active low |
| shift_out_i | input | 1 | Direction: 1 = host to block, 0 = block to host |
| sr_data_i | input | DATA_W | Current shift-register byte from the host side |
| req_n_o | output | 1 | Request line to the host, active low |
| sr_load_o | output | 1 | One-cycle strobe: load `sr_data_o` into the shift register |
| sr_data_o | output | DATA_W | Response byte for the shift register |
| sr_irq_o | output | 1 | Delayed one-cycle shift-register interrupt |
| rsp_we_i | input | 1 | Response buffer write enable |
| rsp_waddr_i | input | $clog2(IN_DEPTH) | Response buffer write index |
| rsp_wdata_i | input | DATA_W | Response buffer write byte |
| rsp_commit_i | input | 1 | Start sending a response of `rsp_len_i` bytes |
| rsp_len_i | input | $clog2(IN_DEPTH+1) | Response length in bytes |
| pkt_valid_o | output | 1 | One-cycle packet-received strobe |
| pkt_len_o | output | $clog2(OUT_DEPTH+1) | Number of bytes in the received packet |
| pkt_raddr_i | input | $clog2(OUT_DEPTH) | Outbound buffer read index |
| pkt_rdata_o | output | DATA_W | Outbound buffer byte, one cycle after the address |

## Verification
The hardest cases to reach from the ports are the timing cases of the interrupt timer. One is a second event that lands while a pulse is still pending. The other is an end of transfer that carries no outbound bytes. To reach them, the bench holds every input steady until earlier pulses have drained. It then times the pulse from a single busy release, and separately from two acknowledge toggles five cycles apart, and counts the pulses over a window twice the delay. It also sends more bytes than the outbound buffer can hold. It re-commits a response after a partial read, to show that the response index starts again at byte 0.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Snapshot of the two host-driven handshake lines (both active low).
  typedef struct packed {
    logic ack_n;
    logic busy_n;
  } hs_pair_t;

  localparam hs_pair_t HS_IDLE = '{ack_n: 1'b1, busy_n: 1'b1};

endpackage

// File: rtl/hs_byte_ram.sv
// Simple dual-port byte store: one write port, one registered read port.
module hs_byte_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    rd_q <= mem[raddr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/hs_irq_delay.sv
// Retriggerable delay: irq_o pulses DELAY edges after the edge that saw start_i.
module hs_irq_delay #(
  parameter int DELAY = 20,
  localparam int CW   = (DELAY < 1) ? 1 : $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic irq_o
);

  logic irq_q;

  generate
    if (DELAY == 0) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= start_i;
      end
    end else begin : g_count
      localparam logic [CW-1:0] LOAD = CW'(DELAY);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          irq_q <= 1'b0;
        end else if (start_i) begin
          cnt_q <= LOAD;
          irq_q <= 1'b0;
        end else if (cnt_q == CW'(1)) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
          irq_q <= 1'b0;
        end
      end
    end
  endgenerate

  assign irq_o = irq_q;

endmodule

// File: rtl/hs_edge_ctl.sv
// Handshake decoder: turns line changes into byte steps, tracks both
// buffer indices and drives the request line.
module hs_edge_ctl
  import hs_pkg::*;
#(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  localparam int OAW = (OUT_DEPTH < 2) ? 1 : $clog2(OUT_DEPTH),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int IAW = (IN_DEPTH < 2) ? 1 : $clog2(IN_DEPTH),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy_n_i,
  input  logic           ack_n_i,
  input  logic           shift_out_i,
  input  logic           commit_i,
  input  logic [ICW-1:0] commit_len_i,
  output logic           out_we_o,
  output logic [OAW-1:0] out_waddr_o,
  output logic [IAW-1:0] in_raddr_o,
  output logic           in_adv_o,
  output logic           pkt_fire_o,
  output logic [OCW-1:0] pkt_len_o,
  output logic           irq_start_o,
  output logic           req_n_o
);

  localparam logic [OCW-1:0] OUT_CAP = OCW'(OUT_DEPTH);
  localparam logic [ICW-1:0] IN_CAP  = ICW'(IN_DEPTH);

  hs_pair_t       now_s, last_q;
  logic [OCW-1:0] out_cnt_q;
  logic [ICW-1:0] in_idx_q, in_len_q, in_idx_nxt, len_capped;
  logic           req_q, req_nxt;

  logic changed, active, in_left, out_adv, in_adv, last_byte;
  logic sync_tog, xfer_end, pkt_fire;

  assign now_s    = '{ack_n: ack_n_i, busy_n: busy_n_i};
  assign changed  = (now_s != last_q);
  assign active   = ~busy_n_i;
  assign in_left  = (in_idx_q < in_len_q);

  // byte steps in each direction
  assign out_adv   = active & shift_out_i & changed & (out_cnt_q < OUT_CAP);
  assign in_adv    = active & ~shift_out_i & changed & in_left & ~commit_i;
  assign last_byte = ((in_idx_q + ICW'(1)) >= in_len_q);

  // idle-time events
  assign sync_tog = busy_n_i & last_q.busy_n & (ack_n_i != last_q.ack_n);
  assign xfer_end = busy_n_i & ~last_q.busy_n;
  assign pkt_fire = xfer_end & (out_cnt_q != '0);

  assign len_capped = (commit_len_i > IN_CAP) ? IN_CAP : commit_len_i;

  always_comb begin
    in_idx_nxt = in_idx_q;
    if (commit_i)    in_idx_nxt = '0;
    else if (in_adv) in_idx_nxt = in_idx_q + ICW'(1);
  end

  always_comb begin
    req_nxt = req_q;
    if (in_adv && last_byte)          req_nxt = 1'b1;
    else if (sync_tog)                req_nxt = ack_n_i;
    else if (busy_n_i && in_left)     req_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= HS_IDLE;
      out_cnt_q <= '0;
      in_idx_q  <= '0;
      in_len_q  <= '0;
      req_q     <= 1'b1;
    end else begin
      last_q   <= now_s;
      in_idx_q <= in_idx_nxt;
      req_q    <= req_nxt;
      if (commit_i) in_len_q <= len_capped;
      if (pkt_fire)     out_cnt_q <= '0;
      else if (out_adv) out_cnt_q <= out_cnt_q + OCW'(1);
    end
  end

  assign out_we_o    = out_adv;
  assign out_waddr_o = out_cnt_q[OAW-1:0];
  assign in_raddr_o  = in_idx_nxt[IAW-1:0];
  assign in_adv_o    = in_adv;
  assign pkt_fire_o  = pkt_fire;
  assign pkt_len_o   = out_cnt_q;
  assign irq_start_o = out_adv | in_adv | sync_tog | xfer_end | commit_i;
  assign req_n_o     = req_q;

endmodule

// File: rtl/hs_byte_xfer.sv
// Top: three-wire handshake byte mover between host shift register and buffers.
module hs_byte_xfer #(
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  parameter int IRQ_DELAY = 20
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            busy_n_i,
  input  logic                            ack_n_i,
  input  logic                            shift_out_i,
  input  logic [DATA_W-1:0]               sr_data_i,
  output logic                            req_n_o,
  output logic                            sr_load_o,
  output logic [DATA_W-1:0]               sr_data_o,
  output logic                            sr_irq_o,
  input  logic                            rsp_we_i,
  input  logic [$clog2(IN_DEPTH)-1:0]     rsp_waddr_i,
  input  logic [DATA_W-1:0]               rsp_wdata_i,
  input  logic                            rsp_commit_i,
  input  logic [$clog2(IN_DEPTH+1)-1:0]   rsp_len_i,
  output logic                            pkt_valid_o,
  output logic [$clog2(OUT_DEPTH+1)-1:0]  pkt_len_o,
  input  logic [$clog2(OUT_DEPTH)-1:0]    pkt_raddr_i,
  output logic [DATA_W-1:0]               pkt_rdata_o
);

  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam int IAW = $clog2(IN_DEPTH);

  logic           out_we, in_adv, pkt_fire, irq_start;
  logic [OAW-1:0] out_waddr;
  logic [IAW-1:0] in_raddr;
  logic [OCW-1:0] pkt_len;
  logic [DATA_W-1:0] in_rdata;

  logic              sr_load_q, pkt_valid_q;
  logic [DATA_W-1:0] sr_data_q;
  logic [OCW-1:0]    pkt_len_q;

  hs_edge_ctl #(
    .OUT_DEPTH (OUT_DEPTH),
    .IN_DEPTH  (IN_DEPTH)
  ) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .busy_n_i     (busy_n_i),
    .ack_n_i      (ack_n_i),
    .shift_out_i  (shift_out_i),
    .commit_i     (rsp_commit_i),
    .commit_len_i (rsp_len_i),
    .out_we_o     (out_we),
    .out_waddr_o  (out_waddr),
    .in_raddr_o   (in_raddr),
    .in_adv_o     (in_adv),
    .pkt_fire_o   (pkt_fire),
    .pkt_len_o    (pkt_len),
    .irq_start_o  (irq_start),
    .req_n_o      (req_n_o)
  );

  // outbound packet store: written by byte steps, read by the consumer
  hs_byte_ram #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_ram (
    .clk     (clk),
    .we_i    (out_we),
    .waddr_i (out_waddr),
    .wdata_i (sr_data_i),
    .raddr_i (pkt_raddr_i),
    .rdata_o (pkt_rdata_o)
  );

  // response store: read address runs one step ahead so data is ready
  hs_byte_ram #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_ram (
    .clk     (clk),
    .we_i    (rsp_we_i),
    .waddr_i (rsp_waddr_i),
    .wdata_i (rsp_wdata_i),
    .raddr_i (in_raddr),
    .rdata_o (in_rdata)
  );

  hs_irq_delay #(.DELAY(IRQ_DELAY)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .start_i (irq_start),
    .irq_o   (sr_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_load_q   <= 1'b0;
      sr_data_q   <= '0;
      pkt_valid_q <= 1'b0;
      pkt_len_q   <= '0;
    end else begin
      sr_load_q   <= in_adv;
      pkt_valid_q <= pkt_fire;
      if (in_adv)   sr_data_q <= in_rdata;
      if (pkt_fire) pkt_len_q <= pkt_len;
    end
  end

  assign sr_load_o   = sr_load_q;
  assign sr_data_o   = sr_data_q;
  assign pkt_valid_o = pkt_valid_q;
  assign pkt_len_o   = pkt_len_q;

endmodule

// File: rtl/hs_byte_xfer_chk.sv
// Property checker for hs_byte_xfer, attached by bind.
module hs_byte_xfer_chk #(
  parameter int OUT_DEPTH = 16,
  parameter int IRQ_DELAY = 20,
  localparam int OCW = $clog2(OUT_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           busy_n_i,
  input logic           ack_n_i,
  input logic           shift_out_i,
  input logic           req_n_o,
  input logic           sr_load_o,
  input logic           sr_irq_o,
  input logic           pkt_valid_o,
  input logic [OCW-1:0] pkt_len_o
);

  // cycles since reset, saturating at 2, so $past depth 2 is meaningful
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_pkt_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_o |-> (pkt_len_o != '0));

  assert_pkt_len_cap_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_o |-> (pkt_len_o <= OCW'(OUT_DEPTH)));

  assert_pkt_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_o && warm_q == 2'd2) |-> ($past(busy_n_i) && !$past(busy_n_i, 2)));

  assert_load_inbound_R6: assert property (@(posedge clk) disable iff (rst)
    (sr_load_o && warm_q != 2'd0) |-> (!$past(busy_n_i) && !$past(shift_out_i)));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
    (sr_irq_o && IRQ_DELAY > 1) |=> !sr_irq_o);

  assert_sync_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2 && $past(busy_n_i) && $past(busy_n_i, 2)
     && ($past(ack_n_i) != $past(ack_n_i, 2)))
    |-> (req_n_o == $past(ack_n_i)));

endmodule

bind hs_byte_xfer hs_byte_xfer_chk #(
  .OUT_DEPTH (OUT_DEPTH),
  .IRQ_DELAY (IRQ_DELAY)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_n_i    (busy_n_i),
  .ack_n_i     (ack_n_i),
  .shift_out_i (shift_out_i),
  .req_n_o     (req_n_o),
  .sr_load_o   (sr_load_o),
  .sr_irq_o    (sr_irq_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_len_o   (pkt_len_o)
);

// File: tb/hs_byte_xfer_tb.sv
module hs_byte_xfer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DLY = 20;
  localparam int OD  = 4;
  localparam int ID  = 16;

  // sync-toggle table: {busy_n, ack_n, expected req_n}
  localparam logic [2:0] SYNC_TBL [6] = '{3'b100, 3'b111, 3'b111,
                                          3'b100, 3'b100, 3'b111};

  logic clk = 1'b0;
  logic rst;
  logic busy_n, ack_n, shift_out;
  logic [7:0] sr_in;
  logic req_n, sr_load, sr_irq, pkt_valid;
  logic [7:0] sr_out, pkt_rdata;
  logic rsp_we, rsp_commit;
  logic [3:0] rsp_waddr;
  logic [7:0] rsp_wdata;
  logic [4:0] rsp_len;
  logic [2:0] pkt_len;
  logic [1:0] pkt_raddr;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hs_byte_xfer #(
    .DATA_W (8), .OUT_DEPTH (OD), .IN_DEPTH (ID), .IRQ_DELAY (DLY)
  ) u_dut (
    .clk (clk), .rst (rst),
    .busy_n_i (busy_n), .ack_n_i (ack_n), .shift_out_i (shift_out),
    .sr_data_i (sr_in), .req_n_o (req_n), .sr_load_o (sr_load),
    .sr_data_o (sr_out), .sr_irq_o (sr_irq),
    .rsp_we_i (rsp_we), .rsp_waddr_i (rsp_waddr), .rsp_wdata_i (rsp_wdata),
    .rsp_commit_i (rsp_commit), .rsp_len_i (rsp_len),
    .pkt_valid_o (pkt_valid), .pkt_len_o (pkt_len),
    .pkt_raddr_i (pkt_raddr), .pkt_rdata_o (pkt_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int np;
    int irq_at;
    int n_irq;
    rst = 1'b1; busy_n = 1'b1; ack_n = 1'b1; shift_out = 1'b0; sr_in = '0;
    rsp_we = 1'b0; rsp_waddr = '0; rsp_wdata = '0; rsp_commit = 1'b0;
    rsp_len = '0; pkt_raddr = '0;
    nxt(3);
    chk("R1 req_n", req_n, 1);
    chk("R1 irq", sr_irq, 0);
    chk("R1 pkt_valid", pkt_valid, 0);
    chk("R1 sr_load", sr_load, 0);
    rst = 1'b0;
    nxt(1);
    chk("R1 req_n after release", req_n, 1);

    // R8: idle sync toggles walked from the table
    for (int i = 0; i < 6; i++) begin
      busy_n = SYNC_TBL[i][2];
      ack_n  = SYNC_TBL[i][1];
      nxt(1);
      chk("R8 req follows ack", req_n, int'(SYNC_TBL[i][0]));
    end
    nxt(DLY + 3);

    // R2/R3/R5/R10: outbound packet of three bytes
    shift_out = 1'b1; sr_in = 8'hA0; busy_n = 1'b0; nxt(1);
    sr_in = 8'hA1; ack_n = 1'b0; nxt(1);
    sr_in = 8'hA2; ack_n = 1'b1; nxt(1);
    sr_in = 8'hFF; nxt(1);                 // no line change: no step (R2)
    busy_n = 1'b1; nxt(1);
    chk("R5 pkt_valid", pkt_valid, 1);
    chk("R2 pkt_len", pkt_len, 3);
    nxt(DLY - 1);
    chk("R10 irq not yet", sr_irq, 0);
    chk("R5 pkt_valid one cycle", pkt_valid, 0);
    nxt(1);
    chk("R10 irq on time", sr_irq, 1);
    nxt(1);
    chk("R10 irq one cycle", sr_irq, 0);
    for (int i = 0; i < 3; i++) begin
      pkt_raddr = 2'(i);
      nxt(1);
      chk("R3 stored byte", pkt_rdata, 8'hA0 + i);
    end

    // R4: six bytes into a four-entry buffer
    sr_in = 8'hB0; busy_n = 1'b0; nxt(1);
    for (int i = 1; i < 6; i++) begin
      sr_in = 8'hB0 + 8'(i); ack_n = ~ack_n; nxt(1);
    end
    busy_n = 1'b1; nxt(1);
    chk("R4 pkt_valid", pkt_valid, 1);
    chk("R4 capped length", pkt_len, OD);
    pkt_raddr = 2'd3; nxt(1);
    chk("R4 last kept byte", pkt_rdata, 8'hB3);
    pkt_raddr = 2'd0; nxt(1);
    chk("R4 first byte", pkt_rdata, 8'hB0);

    // R5/R10: release with no outbound bytes
    shift_out = 1'b0; nxt(DLY + 3);
    busy_n = 1'b0; nxt(1);
    busy_n = 1'b1;
    np = 0; irq_at = 0;
    for (int k = 1; k <= DLY + 2; k++) begin
      nxt(1);
      if (pkt_valid) np++;
      if (sr_irq) irq_at = k;
    end
    chk("R5 no strobe on empty", np, 0);
    chk("R10 irq after empty release", irq_at, DLY + 1);

    // R6/R7/R9/R12: inbound response of three bytes
    for (int i = 0; i < 3; i++) begin
      rsp_we = 1'b1; rsp_waddr = 4'(i); rsp_wdata = 8'h11 * 8'(i + 1); nxt(1);
    end
    rsp_we = 1'b0;
    rsp_commit = 1'b1; rsp_len = 5'd3; nxt(1);
    rsp_commit = 1'b0; nxt(1);
    chk("R9 req asserted with data", req_n, 0);
    nxt(DLY - 2);
    chk("R12 irq not yet after commit", sr_irq, 0);
    nxt(1);
    chk("R12 irq after commit", sr_irq, 1);
    busy_n = 1'b0; nxt(1);               // ack_n is 0 here
    chk("R6 load 1", sr_load, 1);
    chk("R6 byte 1", sr_out, 8'h11);
    ack_n = 1'b1; nxt(1);
    chk("R6 byte 2", sr_out, 8'h22);
    chk("R7 req held", req_n, 0);
    ack_n = 1'b0; nxt(1);
    chk("R6 byte 3", sr_out, 8'h33);
    chk("R7 req released", req_n, 1);
    ack_n = 1'b1; nxt(1);
    chk("R6 ignored step load", sr_load, 0);
    chk("R6 ignored step data", sr_out, 8'h33);
    busy_n = 1'b1; nxt(1);
    chk("R9 req idle no data", req_n, 1);

    // R12: re-commit restarts from byte 0
    rsp_commit = 1'b1; rsp_len = 5'd2; nxt(1);
    rsp_commit = 1'b0; nxt(1);
    busy_n = 1'b0; nxt(1);
    chk("R12 restart byte", sr_out, 8'h11);
    busy_n = 1'b1; nxt(DLY + 3);

    // R11: two events five cycles apart give one pulse
    ack_n = 1'b0; nxt(5);
    ack_n = 1'b1;
    n_irq = 0; irq_at = 0;
    for (int k = 1; k <= 2 * DLY; k++) begin
      nxt(1);
      if (sr_irq) begin n_irq++; irq_at = k; end
    end
    chk("R11 single pulse", n_irq, 1);
    chk("R11 timed from latest", irq_at, DLY + 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule